// File: doc/BRIEF.md
# Sector Coincidence Run Controller

This block starts a disc transfer exactly at the beginning of a chosen sector. An external comparator raises a match qualifier while the sector under the heads is the one requested. The block watches the free-running sector strobe. The first strobe that arrives with the qualifier high marks the sector as acquired. The strobe after that starts the run. When the run starts, the block issues a single-cycle load pulse so that the buffered word is the first one written. If the transfer direction is write and the track is not protected, it also raises the write-enable request.

The sector strobe arrives from the disc clock domain. It is synchronised and reduced to a one-cycle event before the arming logic uses it. A stop/clear input returns the controller to idle at any time. A status word is captured when the host issues a read strobe. That word carries a busy bit (run or control bit set) and a sector-acquired bit. All of its other bits are zero.

Top module: `sector_run_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the run flag, the acquired flag, the load pulse, write-enable and the whole status word to 0 at the next clock edge.
- R2: The sector strobe passes through a two-stage synchroniser and an edge detector. A strobe held high for any number of cycles counts as one event. That event takes effect at the third clock edge after the strobe first becomes high.
- R3: A sector event while idle sets the acquired flag only if the match qualifier is high at that edge. A sector event with the qualifier low has no effect.
- R4: The run flag is set only by a sector event that occurs while the acquired flag is already set. The qualifier is not needed for that event. Further events while running change nothing.
- R5: `load_first` is high for exactly one cycle, in the same cycle in which the run flag first reads 1. It pulses once per run.
- R6: At each clock edge `wr_en` is registered as the next run value AND `dir_write` AND NOT `trk_protect`, using the inputs present at that edge. It is never high while the run flag is low.
- R7: At an edge where `stat_rd` is high, `stat_word` captures bit 0 = (run flag OR `ctl_bit`) and bit 5 = acquired flag, using the values before that edge. All other bits are 0. Between reads the word holds.
- R8: `stop_clr` high at an edge clears the acquired and run flags. It takes priority over a sector event at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sect_pulse | input | 1 | Asynchronous sector strobe, active high |
| sect_match | input | 1 | High while the requested sector is under the heads |
| dir_write | input | 1 | 1 = write transfer, 0 = read |
| trk_protect | input | 1 | Track protection active |
| ctl_bit | input | 1 | Host control bit, reported as busy |
| stat_rd | input | 1 | Host status read strobe |
| stop_clr | input | 1 | Return to idle |
| run_flag | output | 1 | Transfer running |
| load_first | output | 1 | One-cycle load of the first word |
| wr_en | output | 1 | Write-enable request |
| stat_word | output | 16 | Captured status (bit 0 busy, bit 5 acquired) |

## Verification
A wrong arming state leaves marks at the ports. If the acquired flag is stuck, it shows in bit 5 at the next status read. If the controller skips the acquire step, the run flag and the load pulse appear one sector event too early. Because these are visible at the first sector strobe after the fault, a per-cycle reference comparison flags them within three clocks of that strobe. A synchroniser of the wrong depth shifts every transition by a cycle. A broken edge detector produces several load pulses from one long strobe, and the bench counts those pulses. A wrong write gate shows on `wr_en` one edge after `dir_write` or `trk_protect` changes.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_ACQ  = 2'd1,
    ARM_RUN  = 2'd2
  } arm_state_t;
endpackage

// File: rtl/sr_pulse_sync.sv
module sr_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic evt
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
      prev <= chain[LAST];
    end
  end

  assign evt = chain[LAST] & ~prev;
endmodule

// File: rtl/sr_arm_ctrl.sv
module sr_arm_ctrl
  import sr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic match,
  input  logic stop,
  output logic acq,
  output logic run,
  output logic run_nxt,
  output logic load
);
  arm_state_t st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ARM_IDLE: if (evt && match) nxt = ARM_ACQ;
      ARM_ACQ:  if (evt)          nxt = ARM_RUN;
      ARM_RUN:                    nxt = ARM_RUN;
      default:                    nxt = ARM_IDLE;
    endcase
    if (stop) nxt = ARM_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ARM_IDLE;
      load <= 1'b0;
    end else begin
      st   <= nxt;
      load <= (st == ARM_ACQ) && (nxt == ARM_RUN);
    end
  end

  assign acq     = (st != ARM_IDLE);
  assign run     = (st == ARM_RUN);
  assign run_nxt = (nxt == ARM_RUN);
endmodule

// File: rtl/sr_status_reg.sv
module sr_status_reg #(
  parameter int W        = 16,
  parameter int BUSY_POS = 0,
  parameter int ACQ_POS  = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic         run,
  input  logic         ctl,
  input  logic         acq,
  output logic [W-1:0] word
);
  logic [W-1:0] snap;

  always_comb begin
    snap           = '0;
    snap[BUSY_POS] = run | ctl;
    snap[ACQ_POS]  = acq;
  end

  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (rd) word <= snap;
  end
endmodule

// File: rtl/sector_run_ctrl.sv
module sector_run_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 16,
  parameter int BUSY_POS    = 0,
  parameter int ACQ_POS     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sect_pulse,
  input  logic              sect_match,
  input  logic              dir_write,
  input  logic              trk_protect,
  input  logic              ctl_bit,
  input  logic              stat_rd,
  input  logic              stop_clr,
  output logic              run_flag,
  output logic              load_first,
  output logic              wr_en,
  output logic [STAT_W-1:0] stat_word
);
  logic sp_evt;
  logic acq_flag;
  logic run_next;

  sr_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(sect_pulse), .evt(sp_evt)
  );

  sr_arm_ctrl u_arm (
    .clk(clk), .rst(rst), .evt(sp_evt), .match(sect_match), .stop(stop_clr),
    .acq(acq_flag), .run(run_flag), .run_nxt(run_next), .load(load_first)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_en <= 1'b0;
    else     wr_en <= run_next & dir_write & ~trk_protect;
  end

  sr_status_reg #(.W(STAT_W), .BUSY_POS(BUSY_POS), .ACQ_POS(ACQ_POS)) u_stat (
    .clk(clk), .rst(rst), .rd(stat_rd), .run(run_flag), .ctl(ctl_bit),
    .acq(acq_flag), .word(stat_word)
  );
endmodule

// File: rtl/sector_run_ctrl_chk.sv
module sector_run_ctrl_chk #(
  parameter int STAT_W   = 16,
  parameter int BUSY_POS = 0,
  parameter int ACQ_POS  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              dir_write,
  input logic              trk_protect,
  input logic              stat_rd,
  input logic              stop_clr,
  input logic              run_flag,
  input logic              load_first,
  input logic              wr_en,
  input logic              acq_flag,
  input logic [STAT_W-1:0] stat_word
);
  localparam logic [STAT_W-1:0] USED = (STAT_W'(1) << BUSY_POS) | (STAT_W'(1) << ACQ_POS);

  p_run_needs_acq_r4: assert property (@(posedge clk) disable iff (rst)
    run_flag |-> acq_flag);
  p_load_single_r5: assert property (@(posedge clk) disable iff (rst)
    load_first |=> !load_first);
  p_load_on_start_r5: assert property (@(posedge clk) disable iff (rst)
    load_first |-> (run_flag && !$past(run_flag)));
  p_wr_needs_run_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> run_flag);
  p_wr_inputs_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(dir_write) && !$past(trk_protect)));
  p_stat_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stat_rd)) |-> $stable(stat_word));
  p_stat_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_word & ~USED) == '0);
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stop_clr)) |-> (!run_flag && !acq_flag));
  p_acq_fall_only_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(acq_flag)) |-> $past(stop_clr));
endmodule

bind sector_run_ctrl sector_run_ctrl_chk #(
  .STAT_W(STAT_W), .BUSY_POS(BUSY_POS), .ACQ_POS(ACQ_POS)
) u_chk (
  .clk(clk), .rst(rst), .dir_write(dir_write), .trk_protect(trk_protect),
  .stat_rd(stat_rd), .stop_clr(stop_clr), .run_flag(run_flag),
  .load_first(load_first), .wr_en(wr_en), .acq_flag(acq_flag),
  .stat_word(stat_word)
);

// File: tb/sector_run_ctrl_test.sv
module sector_run_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sect_pulse = 1'b0, sect_match = 1'b0, dir_write = 1'b0;
  logic        trk_protect = 1'b0, ctl_bit = 1'b0, stat_rd = 1'b0, stop_clr = 1'b0;
  logic        run_flag, load_first, wr_en;
  logic [15:0] stat_word;

  int total = 0;
  int bad   = 0;
  int loads = 0;

  always #4 clk = ~clk;

  sector_run_ctrl uut (
    .clk(clk), .rst(rst), .sect_pulse(sect_pulse), .sect_match(sect_match),
    .dir_write(dir_write), .trk_protect(trk_protect), .ctl_bit(ctl_bit),
    .stat_rd(stat_rd), .stop_clr(stop_clr), .run_flag(run_flag),
    .load_first(load_first), .wr_en(wr_en), .stat_word(stat_word)
  );

  // behavioural reference
  bit m_acq, m_run, m_load, m_wr;
  bit [15:0] m_stat;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    bit ev, n_acq, n_run;
    if (rst) begin
      m_acq = 0; m_run = 0; m_load = 0; m_wr = 0; m_stat = 0;
      hist = '{0, 0, 0};
    end else begin
      ev = hist[1] && !hist[2];
      n_acq = m_acq; n_run = m_run;
      if (stop_clr) begin n_acq = 0; n_run = 0; end
      else if (ev && !m_acq && sect_match) n_acq = 1;
      else if (ev && m_acq && !m_run) n_run = 1;
      if (stat_rd) m_stat = {10'd0, m_acq, 4'd0, (m_run || ctl_bit)};
      m_load = n_run && !m_run;
      m_wr   = n_run && dir_write && !trk_protect;
      m_acq  = n_acq; m_run = n_run;
      hist.push_front(sect_pulse);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (load_first === 1'b1) loads++;
    check(run_flag === m_run, "R4 run_flag", run_flag, m_run);
    check(load_first === m_load, "R5 load_first", load_first, m_load);
    check(wr_en === m_wr, "R6 wr_en", wr_en, m_wr);
    check(stat_word === m_stat, "R7 stat_word", stat_word, m_stat);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi);
    sect_pulse = 1'b1; cyc(hi);
    sect_pulse = 1'b0; cyc(6);
  endtask

  task automatic read_stat();
    stat_rd = 1'b1; cyc(1);
    stat_rd = 1'b0;
  endtask

  initial begin
    cyc(4);
    rst = 1'b0; cyc(1);
    check(run_flag === 0 && wr_en === 0 && load_first === 0 && stat_word === 0,
          "R1 reset state", {run_flag, wr_en, load_first}, 0);

    pulse(3); read_stat();
    check(stat_word[5] === 1'b0, "R3 no match ignored", stat_word, 0);

    sect_match = 1'b1; pulse(3); sect_match = 1'b0; read_stat();
    check(stat_word === 16'h0020, "R3 acquired on match", stat_word, 16'h0020);
    check(run_flag === 1'b0, "R4 not yet running", run_flag, 0);

    dir_write = 1'b1; pulse(8);
    check(loads == 1, "R2 long strobe one event", loads, 1);
    check(run_flag === 1'b1, "R4 run on second event", run_flag, 1);
    check(wr_en === 1'b1, "R6 write enabled", wr_en, 1);
    read_stat();
    check(stat_word === 16'h0021, "R7 busy and acquired", stat_word, 16'h0021);

    pulse(3);
    check(loads == 1 && run_flag === 1'b1, "R5 no repeat load", loads, 1);

    trk_protect = 1'b1; cyc(1);
    check(wr_en === 1'b0, "R6 protect blocks", wr_en, 0);
    trk_protect = 1'b0; cyc(1);
    check(wr_en === 1'b1, "R6 protect released", wr_en, 1);

    stop_clr = 1'b1; cyc(1); stop_clr = 1'b0;
    check(run_flag === 1'b0 && wr_en === 1'b0, "R8 stop clears run", run_flag, 0);
    read_stat();
    check(stat_word === 16'h0000, "R8 stop clears acquired", stat_word, 0);

    ctl_bit = 1'b1; read_stat(); ctl_bit = 1'b0;
    check(stat_word === 16'h0001, "R7 control bit busy", stat_word, 1);

    sect_match = 1'b1; stop_clr = 1'b1; sect_pulse = 1'b1; cyc(6);
    sect_pulse = 1'b0; stop_clr = 1'b0; sect_match = 1'b0; cyc(6);
    read_stat();
    check(stat_word[5] === 1'b0, "R8 stop beats event", stat_word, 0);

    dir_write = 1'b0; sect_match = 1'b1; pulse(3); sect_match = 1'b0; pulse(3);
    check(run_flag === 1'b1 && wr_en === 1'b0, "R6 read run no write", wr_en, 0);
    check(loads == 2, "R5 one load per run", loads, 2);

    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    check(run_flag === 1'b0 && stat_word === 0, "R1 reset mid run", run_flag, 0);

    cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule